// File: doc/BRIEF.md
# Four-State Debug Trigger Sequencer

This block decides when a debug session fires. It walks through three working states and one terminal state. It moves when comparator hits reach it, and each hit is released at the right point in the instruction stream. A comparator set up as "tagged" holds its hit until the core says the tagged opcode is about to execute. A comparator set up as "forced" holds its hit until the next instruction boundary. Software can also skip the comparators entirely and throw the sequencer into its terminal state with a trigger bit.

Reaching the terminal state produces one-cycle pulses: a trace-start request, a breakpoint request, or both, as configured. A breakpoint request comes with a kind code that picks between halting into background debug and taking a software interrupt. A programmable table gives, for each working state and each comparator, the state to go to next. After the terminal action the sequencer disarms itself and waits in the first state until software arms it again.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `seq_state` is 0 (first state), `seq_armed` is 0, and `trace_trig`, `brk_req` and `brk_kind` are 0.
- R2: A cycle with `arm_wr` high sets `seq_armed` to `arm_wdata` and `seq_state` to 0 on the next edge. This applies in any state, and it discards every held comparator hit, including one arriving in that same cycle.
- R3: A hit on a comparator whose `cfg_tag` bit is 0 is held. It acts at the first cycle with `insn_bnd` high that is strictly later than the hit cycle, and `seq_state` changes at the edge ending that cycle.
- R4: A hit on a comparator whose `cfg_tag` bit is 1 ignores `insn_bnd`. It acts at the first later cycle with `op_exec` high.
- R5: State encoding: 0, 1 and 2 are the working states and 3 is the terminal state. A hit by comparator k (A=0, B=1, C=2) in working state s moves to `cfg_next[(s*3+k)*2 +: 2]`.
- R6: When several held hits act in the same cycle, A wins over B and B wins over C. Every hit whose release strobe is high in that cycle is consumed, winner or not.
- R7: `trig_sw` high while armed, in a working state and without `arm_wr`, moves to state 3 on the next edge. This overrides any hit acting in the same cycle.
- R8: On the edge that enters state 3, `trace_trig` rises to `cfg_trace_en` and `brk_req` rises to `cfg_brk_en`, each for exactly that one cycle. `brk_kind` takes `cfg_brk_kind` (0 = halt into background debug, 1 = software interrupt) and holds it until the next entry.
- R9: One cycle after entering state 3, the sequencer returns to state 0 with `seq_armed` at 0.
- R10: While disarmed, comparator hits, strobes and `trig_sw` have no effect: the state stays 0, no pulse appears, and no hit is remembered for after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| trig_sw | input | 1 | Software trigger pulse |
| cmp_hit | input | 3 | Comparator hit pulses, bit 0 = A, 1 = B, 2 = C |
| cfg_tag | input | 3 | Per comparator: 1 = tagged release, 0 = forced release |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| op_exec | input | 1 | Tagged opcode about to execute |
| cfg_next | input | 18 | Next-state table, 2 bits per (state, comparator) |
| cfg_trace_en | input | 1 | Terminal state requests trace start |
| cfg_brk_en | input | 1 | Terminal state requests a breakpoint |
| cfg_brk_kind | input | 1 | Breakpoint kind to report |
| seq_state | output | 2 | Current sequencer state |
| seq_armed | output | 1 | Arm bit readback |
| trace_trig | output | 1 | One-cycle trace-start pulse |
| brk_req | output | 1 | One-cycle breakpoint request |
| brk_kind | output | 1 | Kind of the last breakpoint request |

## Verification
The software trigger and a held comparator hit can both act in the same cycle. The bench sets this up by holding an A hit and then raising `trig_sw` together with `insn_bnd`. The state must land on 3 and not on the table's A target, and the pulses must follow. Separately, two forced hits are made to act on one boundary, to judge that the priority order is applied and that the losing hit is consumed. A behavioural reference model, compared every cycle, judges both cases.

// File: rtl/dbg_seq_pkg.sv
// Shared types for the debug trigger sequencer.
// Assumes a 2-bit state code where the highest code is the terminal state.
package dbg_seq_pkg;
    localparam int SEQ_STATE_W     = 2;
    localparam int SEQ_LIVE_STATES = 3;

    typedef enum logic [SEQ_STATE_W-1:0] {
        SEQ_S1    = 2'd0,
        SEQ_S2    = 2'd1,
        SEQ_S3    = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dbg_match_qual.sv
// Holds comparator hits until their release strobe arrives.
// A tagged comparator releases on op_exec and a forced one on insn_bnd.
// A hit is only ever released by a strobe strictly later than the hit.
// Assumes clr and armed come from registered sequencer state.
module dbg_match_qual #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] tag_sel,
    input  logic         insn_bnd,
    input  logic         op_exec,
    input  logic         armed,
    input  logic         clr,
    output logic [N-1:0] eff
);
    logic [N-1:0] pend_q;
    logic [N-1:0] release_now;

    // Pick the release strobe for each comparator.
    for (genvar k = 0; k < N; k++) begin : g_rel
        assign release_now[k] = tag_sel[k] ? op_exec : insn_bnd;
    end

    assign eff = pend_q & release_now;

    // Keep held hits, consume released ones, add new ones while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (clr) begin
            pend_q <= '0;
        end else if (armed) begin
            pend_q <= (pend_q & ~release_now) | hit;
        end
    end
endmodule

// File: rtl/dbg_prio_sel.sv
// Fixed-priority pick among acting comparators; the lowest index wins.
// Pure combinational logic, with no assumption on how many bits are set.
module dbg_prio_sel #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  eff,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from high to low so that the lowest set index wins.
    always_comb begin
        any = |eff;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (eff[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/dbg_seq_fsm.sv
// Sequencer state, arm bit, table lookup and terminal-state action pulses.
// Priority: arm write, then terminal exit, then software trigger, then a hit.
// Assumes hit_any and hit_idx come from the hit qualifier of the same cycle.
module dbg_seq_fsm
    import dbg_seq_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int TW = SEQ_LIVE_STATES * N * SEQ_STATE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm_wr,
    input  logic                   arm_wdata,
    input  logic                   trig_sw,
    input  logic                   hit_any,
    input  logic [IW-1:0]          hit_idx,
    input  logic [TW-1:0]          cfg_next,
    input  logic                   cfg_trace_en,
    input  logic                   cfg_brk_en,
    input  logic                   cfg_brk_kind,
    output logic [SEQ_STATE_W-1:0] state,
    output logic                   armed,
    output logic                   clr_pend,
    output logic                   trace_trig,
    output logic                   brk_req,
    output logic                   brk_kind
);
    logic [SEQ_LIVE_STATES-1:0][N-1:0][SEQ_STATE_W-1:0] tbl;
    seq_state_e                st_q, st_n;
    logic                      armed_q, armed_n;
    logic                      fire;
    logic [SEQ_STATE_W-1:0]    route;
    logic                      trace_q, brk_q, kind_q;

    assign tbl = cfg_next;

    // Look up the table entry for the current state and winning comparator.
    always_comb begin
        route = '0;
        for (int s = 0; s < SEQ_LIVE_STATES; s++) begin
            for (int k = 0; k < N; k++) begin
                if (int'(st_q) == s && int'(hit_idx) == k) route = tbl[s][k];
            end
        end
    end

    // Next state, arm bit, hit clear and the terminal-state fire decision.
    always_comb begin
        st_n     = st_q;
        armed_n  = armed_q;
        fire     = 1'b0;
        clr_pend = 1'b0;
        if (arm_wr) begin
            armed_n  = arm_wdata;
            st_n     = SEQ_S1;
            clr_pend = 1'b1;
        end else if (armed_q) begin
            if (st_q == SEQ_FINAL) begin
                st_n     = SEQ_S1;
                armed_n  = 1'b0;
                clr_pend = 1'b1;
            end else if (trig_sw) begin
                st_n = SEQ_FINAL;
                fire = 1'b1;
            end else if (hit_any) begin
                st_n = seq_state_e'(route);
                fire = (route == SEQ_FINAL);
            end
        end
    end

    // Register the state, the arm bit and the action outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_S1;
            armed_q <= 1'b0;
            trace_q <= 1'b0;
            brk_q   <= 1'b0;
            kind_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            armed_q <= armed_n;
            trace_q <= fire & cfg_trace_en;
            brk_q   <= fire & cfg_brk_en;
            if (fire) kind_q <= cfg_brk_kind;
        end
    end

    assign state      = st_q;
    assign armed      = armed_q;
    assign trace_trig = trace_q;
    assign brk_req    = brk_q;
    assign brk_kind   = kind_q;
endmodule

// File: rtl/dbg_seq_top.sv
// Top of the debug trigger sequencer: hit qualifier, priority pick, state machine.
// Assumes comparator hits are single-cycle pulses synchronous to clk.
module dbg_seq_top
    import dbg_seq_pkg::*;
#(
    parameter int NUM_CMP = 3
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          arm_wr,
    input  logic                                          arm_wdata,
    input  logic                                          trig_sw,
    input  logic [NUM_CMP-1:0]                            cmp_hit,
    input  logic [NUM_CMP-1:0]                            cfg_tag,
    input  logic                                          insn_bnd,
    input  logic                                          op_exec,
    input  logic [SEQ_LIVE_STATES*NUM_CMP*SEQ_STATE_W-1:0] cfg_next,
    input  logic                                          cfg_trace_en,
    input  logic                                          cfg_brk_en,
    input  logic                                          cfg_brk_kind,
    output logic [SEQ_STATE_W-1:0]                        seq_state,
    output logic                                          seq_armed,
    output logic                                          trace_trig,
    output logic                                          brk_req,
    output logic                                          brk_kind
);
    localparam int IW = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
    localparam int TW = SEQ_LIVE_STATES * NUM_CMP * SEQ_STATE_W;

    logic [NUM_CMP-1:0] eff;
    logic               hit_any;
    logic [IW-1:0]      hit_idx;
    logic               clr_pend;

    dbg_match_qual #(.N(NUM_CMP)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (cmp_hit),
        .tag_sel  (cfg_tag),
        .insn_bnd (insn_bnd),
        .op_exec  (op_exec),
        .armed    (seq_armed),
        .clr      (clr_pend),
        .eff      (eff)
    );

    dbg_prio_sel #(.N(NUM_CMP), .IW(IW)) u_prio (
        .eff (eff),
        .any (hit_any),
        .idx (hit_idx)
    );

    dbg_seq_fsm #(.N(NUM_CMP), .IW(IW), .TW(TW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_wr       (arm_wr),
        .arm_wdata    (arm_wdata),
        .trig_sw      (trig_sw),
        .hit_any      (hit_any),
        .hit_idx      (hit_idx),
        .cfg_next     (cfg_next),
        .cfg_trace_en (cfg_trace_en),
        .cfg_brk_en   (cfg_brk_en),
        .cfg_brk_kind (cfg_brk_kind),
        .state        (seq_state),
        .armed        (seq_armed),
        .clr_pend     (clr_pend),
        .trace_trig   (trace_trig),
        .brk_req      (brk_req),
        .brk_kind     (brk_kind)
    );
endmodule

// File: rtl/dbg_seq_chk.sv
// Temporal checks on the sequencer ports, bound into dbg_seq_top.
module dbg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_wr,
    input logic       arm_wdata,
    input logic       trig_sw,
    input logic [1:0] seq_state,
    input logic       seq_armed,
    input logic       trace_trig,
    input logic       brk_req
);
    // R2: an arm write sets the bit and restarts in the first state.
    p_arm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (seq_armed == $past(arm_wdata)) && (seq_state == 2'd0));

    // R7: the software trigger goes straight to the terminal state.
    p_trig_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_armed && !arm_wr && trig_sw && seq_state != 2'd3) |=> (seq_state == 2'd3));

    // R8: action pulses appear only in the terminal state.
    p_pulse_in_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_trig || brk_req) |-> (seq_state == 2'd3));

    // R8: the trace pulse lasts a single cycle.
    p_trace_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trace_trig |=> !trace_trig);

    // R9: the terminal state lasts one cycle and disarms.
    p_final_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd3 && !arm_wr) |=> (seq_state == 2'd0) && !seq_armed);

    // R10: disarmed means resting in the first state.
    p_disarmed_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_armed |-> (seq_state == 2'd0));

    // R10: no pulses follow a disarmed cycle without an arm write.
    p_disarmed_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_armed && !arm_wr) |=> !trace_trig && !brk_req);
endmodule

bind dbg_seq_top dbg_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_wr     (arm_wr),
    .arm_wdata  (arm_wdata),
    .trig_sw    (trig_sw),
    .seq_state  (seq_state),
    .seq_armed  (seq_armed),
    .trace_trig (trace_trig),
    .brk_req    (brk_req)
);

// File: tb/tb_dbg_seq_top.sv
module tb_dbg_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_wr = 1'b0, arm_wdata = 1'b0, trig_sw = 1'b0;
    logic [2:0]  cmp_hit = '0, cfg_tag = '0;
    logic        insn_bnd = 1'b0, op_exec = 1'b0;
    logic [17:0] cfg_next = '0;
    logic        cfg_trace_en = 1'b1, cfg_brk_en = 1'b1, cfg_brk_kind = 1'b0;
    logic [1:0]  seq_state;
    logic        seq_armed, trace_trig, brk_req, brk_kind;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    int m_st = 0, m_arm = 0, m_tt = 0, m_br = 0, m_bk = 0;
    bit [2:0] m_pend = '0;

    always #5 clk = ~clk;

    dbg_seq_top dut (
        .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
        .trig_sw(trig_sw), .cmp_hit(cmp_hit), .cfg_tag(cfg_tag),
        .insn_bnd(insn_bnd), .op_exec(op_exec), .cfg_next(cfg_next),
        .cfg_trace_en(cfg_trace_en), .cfg_brk_en(cfg_brk_en),
        .cfg_brk_kind(cfg_brk_kind), .seq_state(seq_state),
        .seq_armed(seq_armed), .trace_trig(trace_trig), .brk_req(brk_req),
        .brk_kind(brk_kind)
    );

    // Behavioural model of the requirements, stepped on each rising edge.
    always @(posedge clk) begin
        bit [2:0] rel, act;
        int win;
        if (!rst_n) begin
            m_st = 0; m_arm = 0; m_tt = 0; m_br = 0; m_bk = 0; m_pend = '0;
        end else begin
            for (int k = 0; k < 3; k++) rel[k] = cfg_tag[k] ? op_exec : insn_bnd;
            act = m_pend & rel;
            m_tt = 0; m_br = 0;
            if (arm_wr) begin
                m_arm = arm_wdata; m_st = 0; m_pend = '0;
            end else if (m_arm == 1) begin
                if (m_st == 3) begin
                    m_st = 0; m_arm = 0; m_pend = '0;
                end else begin
                    m_pend = (m_pend & ~rel) | cmp_hit;
                    win = -1;
                    for (int k = 2; k >= 0; k--) if (act[k]) win = k;
                    if (trig_sw) m_st = 3;
                    else if (win >= 0) m_st = int'(cfg_next[(m_st*3+win)*2 +: 2]);
                    if (m_st == 3) begin
                        m_tt = cfg_trace_en; m_br = cfg_brk_en; m_bk = cfg_brk_kind;
                    end
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "seq_state", int'(seq_state), m_st);
            chk(cur_req, "seq_armed", int'(seq_armed), m_arm);
            chk(cur_req, "trace_trig", int'(trace_trig), m_tt);
            chk(cur_req, "brk_req", int'(brk_req), m_br);
            chk(cur_req, "brk_kind", int'(brk_kind), m_bk);
        end
    end

    task automatic tick();
        @(negedge clk);
        cmp_hit = '0; insn_bnd = 0; op_exec = 0; trig_sw = 0; arm_wr = 0;
    endtask

    task automatic arm(bit v);
        arm_wr = 1; arm_wdata = v; tick();
    endtask

    task automatic set_tbl(int s, int k, int v);
        cfg_next[(s*3+k)*2 +: 2] = 2'(v);
    endtask

    initial begin
        // State 0: A->1 B->2 C->3; state 1: A->0 B->2 C->3; state 2: A->3 B->1 C->0
        set_tbl(0,0,1); set_tbl(0,1,2); set_tbl(0,2,3);
        set_tbl(1,0,0); set_tbl(1,1,2); set_tbl(1,2,3);
        set_tbl(2,0,3); set_tbl(2,1,1); set_tbl(2,2,0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset state", int'(seq_state), 0);
        chk("R1", "reset armed", int'(seq_armed), 0);
        chk("R1", "reset pulses", int'(trace_trig | brk_req | brk_kind), 0);

        cur_req = "R10";
        cmp_hit = 3'b001; tick();
        insn_bnd = 1; trig_sw = 1; tick();
        chk("R10", "disarmed state", int'(seq_state), 0);
        chk("R10", "disarmed trace", int'(trace_trig), 0);
        cur_req = "R2";
        arm(1);
        chk("R2", "armed after write", int'(seq_armed), 1);
        cur_req = "R10";
        insn_bnd = 1; tick();
        chk("R10", "hit before arm forgotten", int'(seq_state), 0);

        cur_req = "R3";
        cmp_hit = 3'b001; insn_bnd = 1; tick();
        chk("R3", "same-cycle boundary ignored", int'(seq_state), 0);
        tick();
        chk("R3", "held without boundary", int'(seq_state), 0);
        insn_bnd = 1; tick();
        chk("R3", "forced hit acts", int'(seq_state), 1);

        cur_req = "R4";
        cfg_tag = 3'b010;
        cmp_hit = 3'b010; tick();
        insn_bnd = 1; tick();
        chk("R4", "tagged ignores boundary", int'(seq_state), 1);
        op_exec = 1; tick();
        chk("R4", "tagged acts on exec", int'(seq_state), 2);

        cur_req = "R6";
        cfg_tag = 3'b000;
        cmp_hit = 3'b110; tick();
        insn_bnd = 1; tick();
        chk("R6", "B wins over C", int'(seq_state), 1);
        insn_bnd = 1; tick();
        chk("R6", "loser consumed", int'(seq_state), 1);

        cur_req = "R7";
        cmp_hit = 3'b001; tick();
        insn_bnd = 1; trig_sw = 1; tick();
        chk("R7", "trigger beats hit", int'(seq_state), 3);
        cur_req = "R8";
        chk("R8", "trace pulse", int'(trace_trig), 1);
        chk("R8", "break pulse", int'(brk_req), 1);
        chk("R8", "kind halt", int'(brk_kind), 0);
        cur_req = "R9";
        tick();
        chk("R9", "back to first", int'(seq_state), 0);
        chk("R9", "self disarm", int'(seq_armed), 0);
        chk("R9", "trace one cycle", int'(trace_trig), 0);

        cur_req = "R8";
        cfg_trace_en = 0; cfg_brk_en = 1; cfg_brk_kind = 1;
        arm(1);
        cmp_hit = 3'b100; tick();
        insn_bnd = 1; tick();
        chk("R8", "entry via C", int'(seq_state), 3);
        chk("R8", "trace disabled", int'(trace_trig), 0);
        chk("R8", "kind interrupt", int'(brk_kind), 1);
        tick();
        chk("R8", "kind held", int'(brk_kind), 1);

        cur_req = "R2";
        arm(1);
        cmp_hit = 3'b001; tick();
        arm_wr = 1; arm_wdata = 0; insn_bnd = 1; tick();
        chk("R2", "disarm write", int'(seq_armed), 0);
        chk("R2", "disarm state", int'(seq_state), 0);
        arm(1);
        insn_bnd = 1; tick();
        chk("R2", "held hit discarded", int'(seq_state), 0);
        cmp_hit = 3'b010; tick();
        insn_bnd = 1; tick();
        chk("R2", "reach state 2", int'(seq_state), 2);
        arm(1);
        chk("R2", "rearm restarts", int'(seq_state), 0);

        cur_req = "R5";
        cfg_trace_en = 1; cfg_brk_en = 0; cfg_brk_kind = 0;
        set_tbl(0,1,2); set_tbl(2,0,3);
        cmp_hit = 3'b010; tick();
        insn_bnd = 1; tick();
        chk("R5", "table s0 B", int'(seq_state), 2);
        cmp_hit = 3'b001; tick();
        insn_bnd = 1; tick();
        chk("R5", "table s2 A", int'(seq_state), 3);
        chk("R5", "break disabled", int'(brk_req), 0);
        chk("R5", "trace enabled", int'(trace_trig), 1);
        tick();
        repeat (3) tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        done = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule